// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block performs the entry sequence into an interrupt or exception for a 16-bit segmented processor. It accepts requests from three classes. The first is an instruction exception: an illegal opcode, or a coprocessor escape fault. The second is a hardware request, which is either non-maskable or maskable. The third is a software interrupt instruction that carries an 8-bit type. While idle, the sequencer picks one request, pulses a one-hot grant, and latches the entry context.

It then pushes three words onto the stack through a word-wide memory port: the flags, the code segment and the return offset. After that it reads the service routine pointer from the vector table at type times four. Finally it presents the new CS:IP, the new flags and the new stack pointer, and pulses done for one clock.

The surrounding core supplies three candidate resume offsets: the start of the current instruction, the start of its segment-override prefix, and the next instruction. The sequencer chooses among them by the kind of request.

Top module: `irq_entry_seq`

## Requirements
- R1: While idle, the block serves exactly one pending request, in this priority order: exception, then non-maskable, then software, then maskable. The grant is one-hot with bit0 for exception, bit1 for non-maskable, bit2 for software and bit3 for maskable, and it is asserted in the cycle the request is taken.
- R2: A maskable request is ignored when bit 9 of cur_flags (interrupt enable) is 0. There is then no grant and busy stays low.
- R3: The block makes three stack writes on consecutive cycles, starting the cycle after the grant. Each write first lowers the stack pointer by 2: flags go to SP-2, CS to SP-4 and the return offset to SP-6. The final new_sp is SP-6.
- R4: For hardware requests, software interrupts and illegal-opcode exceptions, the pushed return offset is next_ip.
- R5: For an escape exception, the pushed return offset is pfx_ip when esc_has_pfx is 1, and insn_ip otherwise.
- R6: After the pushes, the block reads two words from vector space (mem_vec=1): the offset at 4*type, then the segment at 4*type+2. A software request uses sw_type and may name any of the 256 types.
- R7: When done is high, new_ip equals the word read at 4*type and new_cs equals the word read at 4*type+2.
- R8: When done is high, new_flags equals the pushed flags with bit 9 (interrupt enable) and bit 8 (trap) cleared.
- R9: done is a single-cycle pulse, six cycles after the grant cycle.
- R10: After reset, the block is idle: busy, done, mem_we, mem_re and grant are all 0.
- R11: Non-maskable requests use type 2, illegal-opcode exceptions use type 6, and escape exceptions use type 7. A maskable request uses mask_type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Instruction exception pending |
| exc_esc | input | 1 | Exception is an escape fault (1) or an illegal opcode (0) |
| esc_has_pfx | input | 1 | Escape instruction had a segment-override prefix |
| nmi_req | input | 1 | Non-maskable hardware request |
| sw_req | input | 1 | Software interrupt instruction |
| sw_type | input | 8 | Type carried by the software interrupt |
| mask_req | input | 1 | Maskable hardware request |
| mask_type | input | 8 | Type of the maskable request |
| cur_cs | input | 16 | Current code segment |
| insn_ip | input | 16 | Offset of the current instruction |
| pfx_ip | input | 16 | Offset of the segment-override prefix |
| next_ip | input | 16 | Offset of the following instruction |
| cur_flags | input | 16 | Current flags word |
| cur_sp | input | 16 | Current stack pointer |
| mem_rdata | input | 16 | Read data, valid in the same cycle as mem_re |
| grant | output | 4 | One-hot grant pulse |
| busy | output | 1 | Sequence in progress |
| mem_we | output | 1 | Word write strobe |
| mem_re | output | 1 | Word read strobe |
| mem_vec | output | 1 | Access targets the vector table (1) or the stack (0) |
| mem_addr | output | 16 | Word address offset |
| mem_wdata | output | 16 | Write data |
| done | output | 1 | New CS:IP valid, for one cycle |
| new_cs | output | 16 | Service routine segment |
| new_ip | output | 16 | Service routine offset |
| new_flags | output | 16 | Flags after entry |
| new_sp | output | 16 | Stack pointer after the pushes |

## Verification
On every cycle, the assertions check the following: the grant is one-hot, an exception wins whenever one is pending, a lone maskable request is blocked while interrupts are disabled, consecutive pushes step down by two, and vector reads are aligned and step up by two. They also check that done is a single pulse carrying cleared enable and trap bits. Only the bench's scenarios can show that the pushed words hold the right values. The same goes for the choice among the three return offsets for escape faults with and without a prefix, and for the fixed types given to non-maskable and exception requests. They also show that the loaded CS:IP matches the table entry for each type, including types 0 and 255.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
    parameter int WORD_W = 16;
    parameter int TYPE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PSH_FL, ST_PSH_CS, ST_PSH_IP, ST_VEC_LO, ST_VEC_HI
    } seq_st_e;

    typedef struct packed {
        seq_st_e             st;
        logic [WORD_W-1:0]   sp;
        logic [WORD_W-1:0]   cs;
        logic [WORD_W-1:0]   ip;
        logic [WORD_W-1:0]   fl;
        logic [TYPE_W-1:0]   vtype;
        logic                done;
    } seq_regs_t;
endpackage

// File: rtl/irqs_arb.sv
module irqs_arb #(
    parameter int TYPE_W   = 8,
    parameter int NMI_TYPE = 2,
    parameter int ILL_TYPE = 6,
    parameter int ESC_TYPE = 7
) (
    input  logic              exc_req,
    input  logic              exc_esc,
    input  logic              nmi_req,
    input  logic              sw_req,
    input  logic [TYPE_W-1:0] sw_type,
    input  logic              mask_req,
    input  logic [TYPE_W-1:0] mask_type,
    input  logic              int_en,
    output logic [3:0]        win,
    output logic [TYPE_W-1:0] win_type
);
    always_comb begin
        win      = 4'b0000;
        win_type = '0;
        if (exc_req) begin
            win      = 4'b0001;
            win_type = exc_esc ? TYPE_W'(ESC_TYPE) : TYPE_W'(ILL_TYPE);
        end else if (nmi_req) begin
            win      = 4'b0010;
            win_type = TYPE_W'(NMI_TYPE);
        end else if (sw_req) begin
            win      = 4'b0100;
            win_type = sw_type;
        end else if (mask_req && int_en) begin
            win      = 4'b1000;
            win_type = mask_type;
        end
    end
endmodule

// File: rtl/irqs_ret.sv
module irqs_ret #(
    parameter int WORD_W = 16
) (
    input  logic              is_exc,
    input  logic              is_esc,
    input  logic              has_pfx,
    input  logic [WORD_W-1:0] insn_ip,
    input  logic [WORD_W-1:0] pfx_ip,
    input  logic [WORD_W-1:0] next_ip,
    output logic [WORD_W-1:0] ret_ip
);
    always_comb begin
        if (is_exc && is_esc) ret_ip = has_pfx ? pfx_ip : insn_ip;
        else                  ret_ip = next_ip;
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irqs_pkg::*;
#(
    parameter int IF_BIT   = 9,
    parameter int TF_BIT   = 8,
    parameter int NMI_TYPE = 2,
    parameter int ILL_TYPE = 6,
    parameter int ESC_TYPE = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic              exc_esc,
    input  logic              esc_has_pfx,
    input  logic              nmi_req,
    input  logic              sw_req,
    input  logic [TYPE_W-1:0] sw_type,
    input  logic              mask_req,
    input  logic [TYPE_W-1:0] mask_type,
    input  logic [WORD_W-1:0] cur_cs,
    input  logic [WORD_W-1:0] insn_ip,
    input  logic [WORD_W-1:0] pfx_ip,
    input  logic [WORD_W-1:0] next_ip,
    input  logic [WORD_W-1:0] cur_flags,
    input  logic [WORD_W-1:0] cur_sp,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [3:0]        grant,
    output logic              busy,
    output logic              mem_we,
    output logic              mem_re,
    output logic              mem_vec,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              done,
    output logic [WORD_W-1:0] new_cs,
    output logic [WORD_W-1:0] new_ip,
    output logic [WORD_W-1:0] new_flags,
    output logic [WORD_W-1:0] new_sp
);
    localparam int PAD_W = WORD_W - TYPE_W - 2;
    localparam logic [WORD_W-1:0] STEP     = WORD_W'(2);
    localparam logic [WORD_W-1:0] CLR_MASK = ~((WORD_W'(1) << IF_BIT) | (WORD_W'(1) << TF_BIT));

    seq_regs_t         r_q, r_d;
    logic [3:0]        win;
    logic [TYPE_W-1:0] win_type;
    logic [WORD_W-1:0] ret_ip;
    logic [WORD_W-1:0] vec_base;
    logic              idle;

    irqs_arb #(
        .TYPE_W(TYPE_W), .NMI_TYPE(NMI_TYPE), .ILL_TYPE(ILL_TYPE), .ESC_TYPE(ESC_TYPE)
    ) u_arb (
        .exc_req(exc_req), .exc_esc(exc_esc), .nmi_req(nmi_req),
        .sw_req(sw_req), .sw_type(sw_type), .mask_req(mask_req),
        .mask_type(mask_type), .int_en(cur_flags[IF_BIT]),
        .win(win), .win_type(win_type)
    );

    irqs_ret #(.WORD_W(WORD_W)) u_ret (
        .is_exc(exc_req), .is_esc(exc_esc), .has_pfx(esc_has_pfx),
        .insn_ip(insn_ip), .pfx_ip(pfx_ip), .next_ip(next_ip),
        .ret_ip(ret_ip)
    );

    assign idle     = (r_q.st == ST_IDLE);
    assign vec_base = {{PAD_W{1'b0}}, r_q.vtype, 2'b00};

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_vec   = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (|win) begin
                    r_d.st    = ST_PSH_FL;
                    r_d.sp    = cur_sp;
                    r_d.cs    = cur_cs;
                    r_d.ip    = ret_ip;
                    r_d.fl    = cur_flags;
                    r_d.vtype = win_type;
                end
            end
            ST_PSH_FL: begin
                mem_we    = 1'b1;
                mem_addr  = r_q.sp - STEP;
                mem_wdata = r_q.fl;
                r_d.sp    = r_q.sp - STEP;
                r_d.st    = ST_PSH_CS;
            end
            ST_PSH_CS: begin
                mem_we    = 1'b1;
                mem_addr  = r_q.sp - STEP;
                mem_wdata = r_q.cs;
                r_d.sp    = r_q.sp - STEP;
                r_d.st    = ST_PSH_IP;
            end
            ST_PSH_IP: begin
                mem_we    = 1'b1;
                mem_addr  = r_q.sp - STEP;
                mem_wdata = r_q.ip;
                r_d.sp    = r_q.sp - STEP;
                r_d.fl    = r_q.fl & CLR_MASK;
                r_d.st    = ST_VEC_LO;
            end
            ST_VEC_LO: begin
                mem_re   = 1'b1;
                mem_vec  = 1'b1;
                mem_addr = vec_base;
                r_d.ip   = mem_rdata;
                r_d.st   = ST_VEC_HI;
            end
            ST_VEC_HI: begin
                mem_re   = 1'b1;
                mem_vec  = 1'b1;
                mem_addr = vec_base + STEP;
                r_d.cs   = mem_rdata;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign grant     = idle ? win : 4'b0000;
    assign busy      = !idle;
    assign done      = r_q.done;
    assign new_cs    = r_q.cs;
    assign new_ip    = r_q.ip;
    assign new_flags = r_q.fl;
    assign new_sp    = r_q.sp;
endmodule

// File: rtl/irqs_chk.sv
module irqs_chk #(
    parameter int IF_BIT = 9,
    parameter int TF_BIT = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  grant,
    input logic        busy,
    input logic        done,
    input logic        exc_req,
    input logic        nmi_req,
    input logic        sw_req,
    input logic        mask_req,
    input logic [15:0] cur_flags,
    input logic        mem_we,
    input logic        mem_re,
    input logic [15:0] mem_addr,
    input logic [15:0] new_flags
);
    a_r1_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r1_exc_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && exc_req) |-> (grant == 4'b0001));

    a_r2_mask_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mask_req && !exc_req && !nmi_req && !sw_req && !cur_flags[IF_BIT])
        |-> (grant == 4'b0000));

    a_r3_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 16'd2));

    a_r6_vec_align: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && !$past(mem_re)) |-> (mem_addr[1:0] == 2'b00));

    a_r6_vec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + 16'd2));

    a_r8_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!new_flags[IF_BIT] && !new_flags[TF_BIT]));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind irq_entry_seq irqs_chk #(.IF_BIT(IF_BIT), .TF_BIT(TF_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .grant(grant), .busy(busy), .done(done),
    .exc_req(exc_req), .nmi_req(nmi_req), .sw_req(sw_req), .mask_req(mask_req),
    .cur_flags(cur_flags), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .new_flags(new_flags)
);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 0, exc_esc = 0, esc_has_pfx = 0, nmi_req = 0, sw_req = 0, mask_req = 0;
    logic [7:0]  sw_type = 0, mask_type = 0;
    logic [15:0] cur_cs = 0, insn_ip = 0, pfx_ip = 0, next_ip = 0, cur_flags = 0, cur_sp = 0;
    logic [15:0] mem_rdata;
    logic [3:0]  grant;
    logic        busy, mem_we, mem_re, mem_vec, done;
    logic [15:0] mem_addr, mem_wdata, new_cs, new_ip, new_flags, new_sp;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    function automatic logic [15:0] off_of(input logic [7:0] t);
        return {t, ~t} ^ 16'h5A0F;
    endfunction
    function automatic logic [15:0] seg_of(input logic [7:0] t);
        return {~t, t} ^ 16'h1234;
    endfunction

    assign mem_rdata = mem_vec ? (mem_addr[1] ? seg_of(mem_addr[9:2]) : off_of(mem_addr[9:2])) : 16'h0000;

    irq_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_esc(exc_esc),
        .esc_has_pfx(esc_has_pfx), .nmi_req(nmi_req), .sw_req(sw_req),
        .sw_type(sw_type), .mask_req(mask_req), .mask_type(mask_type),
        .cur_cs(cur_cs), .insn_ip(insn_ip), .pfx_ip(pfx_ip), .next_ip(next_ip),
        .cur_flags(cur_flags), .cur_sp(cur_sp), .mem_rdata(mem_rdata),
        .grant(grant), .busy(busy), .mem_we(mem_we), .mem_re(mem_re),
        .mem_vec(mem_vec), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .done(done), .new_cs(new_cs), .new_ip(new_ip), .new_flags(new_flags),
        .new_sp(new_sp)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drop_reqs();
        exc_req = 0; nmi_req = 0; sw_req = 0; mask_req = 0;
    endtask

    task automatic run_case(input bit e, input bit esc, input bit pfx, input bit n,
                            input bit s, input logic [7:0] st, input bit m,
                            input logic [7:0] mt, input logic [15:0] fl);
        logic [3:0]  eg;
        logic [7:0]  et;
        logic [15:0] er, sp0;
        logic [15:0] wa[3], wd[3], ra[2];
        logic        rv[2];
        int nw, nr;
        bit seen;
        string rtag;
        cur_cs = 16'($urandom); insn_ip = 16'($urandom); pfx_ip = 16'($urandom);
        next_ip = 16'($urandom); cur_sp = 16'($urandom) & 16'hFFFE; sp0 = cur_sp;
        cur_flags = fl; exc_esc = esc; esc_has_pfx = pfx; sw_type = st; mask_type = mt;
        exc_req = e; nmi_req = n; sw_req = s; mask_req = m;
        eg = 4'b0000; et = 8'h00;
        if (e)                     begin eg = 4'b0001; et = esc ? 8'd7 : 8'd6; end
        else if (n)                begin eg = 4'b0010; et = 8'd2; end
        else if (s)                begin eg = 4'b0100; et = st; end
        else if (m && fl[9])       begin eg = 4'b1000; et = mt; end
        er = (e && esc) ? (pfx ? pfx_ip : insn_ip) : next_ip;
        rtag = (e && esc) ? "R5" : "R4";
        #1;
        chk(grant == eg, (m && !fl[9] && eg == 0) ? "R2" : "R1", "grant", 32'(grant), 32'(eg));
        if (eg == 4'b0000) begin
            repeat (3) @(negedge clk);
            chk(!busy && !mem_we, "R2", "masked request left block idle", 32'(busy), 0);
            drop_reqs();
            return;
        end
        @(posedge clk);
        @(negedge clk);
        drop_reqs();
        nw = 0; nr = 0; seen = 0;
        for (int k = 0; k < 12 && !seen; k++) begin
            if (mem_we && nw < 3) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; nw++; end
            if (mem_re && nr < 2) begin ra[nr] = mem_addr; rv[nr] = mem_vec; nr++; end
            if (done) begin
                seen = 1;
                chk(k == 5, "R9", "done cycle after grant", 32'(k + 1), 6);
                chk(new_ip == off_of(et), "R7", "new_ip", 32'(new_ip), 32'(off_of(et)));
                chk(new_cs == seg_of(et), "R7", "new_cs", 32'(new_cs), 32'(seg_of(et)));
                chk(new_flags == (fl & 16'hFCFF), "R8", "new_flags", 32'(new_flags), 32'(fl & 16'hFCFF));
                chk(new_sp == sp0 - 16'd6, "R3", "new_sp", 32'(new_sp), 32'(sp0 - 16'd6));
            end else begin
                @(negedge clk);
            end
        end
        chk(seen, "R9", "done seen", 32'(seen), 1);
        chk(nw == 3, "R3", "write count", 32'(nw), 3);
        if (nw == 3) begin
            chk(wa[0] == sp0 - 16'd2 && wd[0] == fl, "R3", "flags push", {wa[0], wd[0]}, {sp0 - 16'd2, fl});
            chk(wa[1] == sp0 - 16'd4 && wd[1] == cur_cs, "R3", "cs push", {wa[1], wd[1]}, {sp0 - 16'd4, cur_cs});
            chk(wa[2] == sp0 - 16'd6, "R3", "ip push addr", 32'(wa[2]), 32'(sp0 - 16'd6));
            chk(wd[2] == er, rtag, "return offset", 32'(wd[2]), 32'(er));
        end
        chk(nr == 2, "R6", "read count", 32'(nr), 2);
        if (nr == 2) begin
            chk(ra[0] == {6'b0, et, 2'b00} && rv[0], (e || n) ? "R11" : "R6", "vector offset addr",
                32'(ra[0]), 32'({6'b0, et, 2'b00}));
            chk(ra[1] == {6'b0, et, 2'b10} && rv[1], "R6", "vector segment addr",
                32'(ra[1]), 32'({6'b0, et, 2'b10}));
        end
        @(negedge clk);
        chk(!done, "R9", "done single pulse", 32'(done), 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_we && !mem_re && grant == 0, "R10", "reset idle",
            {27'b0, busy, done, mem_we, mem_re, |grant}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && grant == 0, "R10", "idle after reset release", 32'(busy), 0);
        // directed: escape with and without prefix, illegal opcode
        run_case(1, 1, 1, 0, 0, 8'h00, 0, 8'h00, 16'h0302);
        run_case(1, 1, 0, 0, 0, 8'h00, 0, 8'h00, 16'h0200);
        run_case(1, 0, 1, 0, 0, 8'h00, 0, 8'h00, 16'h0000);
        // all pending: exception wins; then nmi over sw and maskable
        run_case(1, 0, 0, 1, 1, 8'h40, 1, 8'h41, 16'h0200);
        run_case(0, 0, 0, 1, 1, 8'h40, 1, 8'h41, 16'h0200);
        run_case(0, 0, 0, 0, 1, 8'h40, 1, 8'h41, 16'h0200);
        // software type boundaries
        run_case(0, 0, 0, 0, 1, 8'h00, 0, 8'h00, 16'hFFFF);
        run_case(0, 0, 0, 0, 1, 8'hFF, 0, 8'h00, 16'h0100);
        // maskable enabled, then blocked by clear enable flag
        run_case(0, 0, 0, 0, 0, 8'h00, 1, 8'h20, 16'h0200);
        run_case(0, 0, 0, 0, 0, 8'h00, 1, 8'h20, 16'hFDFF);
        for (int i = 0; i < 60; i++) begin
            run_case(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     1'($urandom), 8'($urandom), 1'($urandom), 8'($urandom),
                     16'($urandom));
            @(negedge clk);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule